// File: doc/BRIEF.md
# Packet Stream Queue Status Unit

This unit keeps, for each of two broadcast data channels, a count of the fixed-size packets still waiting to be consumed, and presents that count and a per-packet status byte to a host through a simple register read port. A loader gives the unit the length of a newly opened stream in bytes. The unit turns that length into a packet count (22 bytes per packet, the last packet possibly partial) with a small serial divider. The host then polls a count register and consumes packets by reading a status register.

The visible count is one byte and is capped at 0x7F, while the internal count is 16 bits wide. Each status read takes one packet off the queue. The status byte flags the first packet of a stream and the final packet. When the host polls the count of a channel whose queue is empty, the channel steps a stream index, and the loader uses that index to pick the next stream. Two fixed configuration registers are readable at reset values 0x10 and 0x80. Storage and delivery of the payload bytes are handled elsewhere.

Top module: `pkt_queue_status`

## Requirements
- R1: A load on a channel sets its queue to ceil(length / 22) held in 16 bits. The channel's `busy` bit stays high from the cycle after the load until that count is in place.
- R2: A count-register read returns 0x7F when the queue holds 128 or more packets, the exact count when it holds fewer, and 0 on a channel that has never been loaded.
- R3: A status-register read on a loaded channel with a non-zero queue removes one packet. Bit 7 of the returned byte is 1 exactly when that read leaves the queue at zero.
- R4: Bit 6 of the status byte is 1 on the first status read after a load that finds packets queued, and 0 on every later read until the next load. Bits 5..0 of the status byte are always 0.
- R5: A count-register read that finds the channel's queue at zero, with the channel not busy, adds one to that channel's 8-bit stream index. Other reads leave the index unchanged. The index is 0 after reset, and channel c's index appears on `stream_idx[8c+7:8c]`.
- R6: While a channel is busy, count and status reads of it return 0 and change neither its queue nor its stream index.
- R7: After reset, index 4 reads 0x10 and index 5 reads 0x80, and both keep those values.
- R8: A status read on an empty or unloaded channel returns 0 and leaves the queue at zero, so the count stays 0.
- R9: The register index selects channel c's count at 2c and its status at 2c+1. Indices 6 and 7 read 0. Read data appears on `rd_data` after the clock edge that samples `rd_strobe` and holds until the next read. Operations on one channel do not change the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Start a new stream on `load_chan` |
| load_chan | input | 1 | Channel being loaded |
| load_len | input | 20 | Stream length in bytes |
| rd_strobe | input | 1 | One-cycle register read request |
| rd_index | input | 3 | Register index of the read |
| rd_data | output | 8 | Registered read result |
| busy | output | 2 | Per-channel packet count computation in progress |
| stream_idx | output | 16 | Per-channel stream index, channel 1 in the upper byte |

## Verification
The assertions assume that `load_valid` is a single-cycle pulse, that `load_len` is small enough for the packet count to fit in 16 bits, and that reads and loads are not issued in the same cycle for the same channel. The stimulus drives every load and read as a one-cycle pulse on the falling edge, keeps stream lengths far below the 16-bit count limit, and waits for `busy` to drop before it reads. The only exception is a dedicated test that reads a busy channel on purpose. Lengths are swept through every value from 0 to 70 so that every rounding case is covered, and each queue is drained one packet past empty.

// File: rtl/pqs_pkg.sv
package pqs_pkg;
    localparam int BYTE_W      = 8;
    localparam int QUEUE_W     = 16;
    localparam int SIDX_W      = 8;
    localparam int LAST_BIT    = 7;
    localparam int FIRST_BIT   = 6;
    localparam logic [BYTE_W-1:0] COUNT_CAP = 8'h7F;
    localparam logic [BYTE_W-1:0] CFG_A_RST = 8'h10;
    localparam logic [BYTE_W-1:0] CFG_B_RST = 8'h80;

    function automatic logic [BYTE_W-1:0] cap_count(input logic [QUEUE_W-1:0] n);
        if (n > QUEUE_W'(COUNT_CAP))
            return COUNT_CAP;
        return n[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/pqs_divider.sv
module pqs_divider #(
    parameter int LEN_W   = 20,
    parameter int Q_W     = 16,
    parameter int DIVISOR = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   quotient
);
    localparam logic [LEN_W-1:0] DIV_L = LEN_W'(DIVISOR);

    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic [Q_W-1:0]   quo;
        logic             busy;
        logic             done;
    } div_s;

    div_s div_d, div_q;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        if (start) begin
            div_d.rem  = len;
            div_d.quo  = '0;
            div_d.busy = 1'b1;
        end else if (div_q.busy) begin
            if (div_q.rem > DIV_L) begin
                div_d.rem = div_q.rem - DIV_L;
                div_d.quo = div_q.quo + Q_W'(1);
            end else begin
                if (div_q.rem != '0)
                    div_d.quo = div_q.quo + Q_W'(1);
                div_d.rem  = '0;
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign busy     = div_q.busy;
    assign done     = div_q.done;
    assign quotient = div_q.quo;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_QUO_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.busy && !start) |-> (div_q.quo != '1)); // R1
endmodule

// File: rtl/pqs_channel.sv
module pqs_channel
    import pqs_pkg::*;
#(
    parameter int LEN_W     = 20,
    parameter int PKT_BYTES = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  len,
    input  logic              cnt_rd,
    input  logic              st_rd,
    output logic [BYTE_W-1:0] cnt_byte,
    output logic [BYTE_W-1:0] st_byte,
    output logic              busy,
    output logic [SIDX_W-1:0] sidx
);
    typedef struct packed {
        logic [QUEUE_W-1:0] queue;
        logic               first;
        logic               loaded;
        logic [SIDX_W-1:0]  sidx;
    } chan_s;

    chan_s ch_d, ch_q;
    logic               div_busy;
    logic               div_done;
    logic [QUEUE_W-1:0] div_quo;

    pqs_divider #(
        .LEN_W  (LEN_W),
        .Q_W    (QUEUE_W),
        .DIVISOR(PKT_BYTES)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (load),
        .len     (len),
        .busy    (div_busy),
        .done    (div_done),
        .quotient(div_quo)
    );

    assign busy = div_busy | div_done;

    always_comb begin
        ch_d = ch_q;
        if (load) begin
            ch_d.loaded = 1'b1;
            ch_d.first  = 1'b1;
            ch_d.queue  = '0;
        end else if (div_done) begin
            ch_d.queue = div_quo;
        end else if (!div_busy) begin
            if (cnt_rd && ch_q.queue == '0)
                ch_d.sidx = ch_q.sidx + SIDX_W'(1);
            if (st_rd && ch_q.loaded && ch_q.queue != '0) begin
                ch_d.queue = ch_q.queue - QUEUE_W'(1);
                ch_d.first = 1'b0;
            end
        end
    end

    always_comb begin
        cnt_byte = '0;
        st_byte  = '0;
        if (!busy && ch_q.loaded) begin
            cnt_byte = cap_count(ch_q.queue);
            if (ch_q.queue != '0) begin
                st_byte[LAST_BIT]  = (ch_q.queue == QUEUE_W'(1));
                st_byte[FIRST_BIT] = ch_q.first;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign sidx = ch_q.sidx;

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_byte <= COUNT_CAP); // R2
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !busy && !load && ch_q.loaded && ch_q.queue != '0)
        |=> (ch_q.queue == $past(ch_q.queue) - QUEUE_W'(1))); // R3
    AST_FIRST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !busy && !load && ch_q.loaded && ch_q.queue != '0) |=> !ch_q.first); // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_q.sidx) |-> (ch_q.sidx == $past(ch_q.sidx) + SIDX_W'(1))); // R5
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !load) |=> (ch_q.queue == '0 && $stable(ch_q.sidx))); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !div_done && ch_q.queue == '0) |=> (ch_q.queue == '0)); // R8
endmodule

// File: rtl/pkt_queue_status.sv
module pkt_queue_status
    import pqs_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int LEN_W     = 20,
    parameter int PKT_BYTES = 22,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W    = $clog2(2 * NUM_CH + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_valid,
    input  logic [CH_W-1:0]          load_chan,
    input  logic [LEN_W-1:0]         load_len,
    input  logic                     rd_strobe,
    input  logic [IDX_W-1:0]         rd_index,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [NUM_CH-1:0]        busy,
    output logic [NUM_CH*SIDX_W-1:0] stream_idx
);
    localparam logic [IDX_W-1:0] CFG_A_IDX = IDX_W'(2 * NUM_CH);
    localparam logic [IDX_W-1:0] CFG_B_IDX = IDX_W'(2 * NUM_CH + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] rd_data;
        logic [BYTE_W-1:0] cfg_a;
        logic [BYTE_W-1:0] cfg_b;
    } top_s;

    top_s top_d, top_q;
    logic [BYTE_W-1:0] ch_cnt [NUM_CH];
    logic [BYTE_W-1:0] ch_st  [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic load_go, cnt_go, st_go;
        assign load_go = load_valid && (load_chan == CH_W'(g));
        assign cnt_go  = rd_strobe && (rd_index == IDX_W'(2 * g));
        assign st_go   = rd_strobe && (rd_index == IDX_W'(2 * g + 1));

        pqs_channel #(
            .LEN_W    (LEN_W),
            .PKT_BYTES(PKT_BYTES)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_go),
            .len     (load_len),
            .cnt_rd  (cnt_go),
            .st_rd   (st_go),
            .cnt_byte(ch_cnt[g]),
            .st_byte (ch_st[g]),
            .busy    (busy[g]),
            .sidx    (stream_idx[g*SIDX_W +: SIDX_W])
        );
    end

    always_comb begin
        logic [BYTE_W-1:0] sel;
        top_d = top_q;
        sel   = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_index == IDX_W'(2 * c))     sel = ch_cnt[c];
            if (rd_index == IDX_W'(2 * c + 1)) sel = ch_st[c];
        end
        if (rd_index == CFG_A_IDX) sel = top_q.cfg_a;
        if (rd_index == CFG_B_IDX) sel = top_q.cfg_b;
        if (rd_strobe)
            top_d.rd_data = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q.rd_data <= '0;
            top_q.cfg_a   <= CFG_A_RST;
            top_q.cfg_b   <= CFG_B_RST;
        end else begin
            top_q <= top_d;
        end
    end

    assign rd_data = top_q.rd_data;

    AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_index == CFG_A_IDX) |=> (rd_data == CFG_A_RST)); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_index > CFG_B_IDX) |=> (rd_data == '0)); // R9
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data)); // R9
endmodule

// File: tb/pkt_queue_status_bench.sv
`timescale 1ns/1ps
module pkt_queue_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [0:0]  load_chan = '0;
    logic [19:0] load_len = '0;
    logic        rd_strobe = 1'b0;
    logic [2:0]  rd_index = '0;
    logic [7:0]  rd_data;
    logic [1:0]  busy;
    logic [15:0] stream_idx;

    int checks = 0;
    int errors = 0;
    int m_queue [2];
    int m_first [2];
    int m_loaded[2];
    int m_sidx  [2];

    always #2.5 clk = ~clk;

    pkt_queue_status u_pkt_queue_status (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_chan(load_chan),
        .load_len(load_len), .rd_strobe(rd_strobe), .rd_index(rd_index),
        .rd_data(rd_data), .busy(busy), .stream_idx(stream_idx)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input int idx, output int v);
        @(negedge clk);
        rd_strobe = 1'b1;
        rd_index  = 3'(idx);
        @(negedge clk);
        rd_strobe = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic do_load(input int ch, input int len);
        @(negedge clk);
        load_valid = 1'b1;
        load_chan  = 1'(ch);
        load_len   = 20'(len);
        @(negedge clk);
        load_valid = 1'b0;
        while (busy[ch]) @(negedge clk);
        m_loaded[ch] = 1;
        m_first[ch]  = 1;
        m_queue[ch]  = (len + 21) / 22;
    endtask

    task automatic read_count(input int ch, input string tag);
        int v, e;
        e = (m_loaded[ch] == 0) ? 0 : ((m_queue[ch] >= 128) ? 127 : m_queue[ch]);
        if (m_queue[ch] == 0) m_sidx[ch] = (m_sidx[ch] + 1) % 256;
        do_read(2 * ch, v);
        check(tag, v, e);
        check("R5 stream index", int'(stream_idx[8*ch +: 8]), m_sidx[ch]);
    endtask

    task automatic read_status(input int ch, input string tag);
        int v, e;
        e = 0;
        if (m_loaded[ch] != 0 && m_queue[ch] > 0) begin
            e = ((m_queue[ch] == 1) ? 128 : 0) + ((m_first[ch] != 0) ? 64 : 0);
            m_queue[ch]--;
            m_first[ch] = 0;
        end
        do_read(2 * ch + 1, v);
        check(tag, v, e);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int v;
        for (int c = 0; c < 2; c++) begin
            m_queue[c] = 0; m_first[c] = 0; m_loaded[c] = 0; m_sidx[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset rd_data", int'(rd_data), 0);
        check("reset busy", int'(busy), 0);
        check("R5 reset index", int'(stream_idx), 0);

        do_read(4, v); check("R7 cfg a", v, 8'h10);
        do_read(5, v); check("R7 cfg b", v, 8'h80);
        do_read(6, v); check("R9 unused 6", v, 0);
        do_read(7, v); check("R9 unused 7", v, 0);
        @(negedge clk);
        check("R9 hold", int'(rd_data), 0);

        read_count(0, "R2 unloaded count");
        read_status(1, "R8 unloaded status");
        read_count(1, "R2 unloaded count ch1");

        // R1 R3 R4 R8: sweep every length 0..70 on channel 0
        for (int len = 0; len <= 70; len++) begin
            do_load(0, len);
            read_count(0, "R1 packet count");
            while (m_queue[0] > 0) read_status(0, "R3 R4 status");
            read_status(0, "R8 extra status");
            read_count(0, "R8 count after drain");
        end

        // R2 saturation with 16-bit queue, R9 channel independence
        do_load(1, 22 * 300);
        read_count(1, "R2 saturated 300");
        do_load(1, 22 * 130 + 5);
        read_count(1, "R2 saturated 131");
        do_load(0, 45);
        for (int k = 0; k < 3; k++) read_status(1, "R3 R4 ch1 drain");
        read_count(1, "R2 128 saturates");
        read_status(1, "R3 ch1 drain");
        read_count(1, "R2 exact 127");
        read_count(0, "R9 ch0 untouched");
        read_status(0, "R4 ch0 first");
        for (int k = 0; k < 27; k++) read_status(1, "R3 ch1 drain");
        read_count(1, "R2 exact 100");

        // R6: reads during busy return 0 and are ignored
        @(negedge clk);
        load_valid = 1'b1; load_chan = 1'b0; load_len = 20'(22 * 100);
        @(negedge clk);
        load_valid = 1'b0;
        check("R1 busy raised", int'(busy[0]), 1);
        do_read(0, v); check("R6 busy count", v, 0);
        do_read(1, v); check("R6 busy status", v, 0);
        check("R6 index unchanged", int'(stream_idx[7:0]), m_sidx[0]);
        while (busy[0]) @(negedge clk);
        m_loaded[0] = 1; m_first[0] = 1; m_queue[0] = 100;
        read_count(0, "R6 count after busy");
        read_status(0, "R6 R4 first after busy");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule